// File: doc/BRIEF.md
# Word-parallel CRC-16 accumulator

This block keeps a 16-bit running check value over a stream of 16-bit words. Each accepted word is folded into the value in a single clock. Both the sending and the receiving side of a word-serial packet link can use it. A clear strobe starts a new packet. A data-valid strobe absorbs one word.

On the receive side, the check word that follows the data is also absorbed. The accumulator then returns to zero. A compare strobe checks an incoming word against the current value. On a mismatch it raises a sticky error flag, which stays set until the next clear.

Top module: `crc16_word`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and on the first cycle after it, `crc` is 0 and `err` is 0.
- R2: When `vld` is high and `clr` is low at a clock edge, `crc` after that edge equals the reduction of `crc ^ din`. The reduction is 16 steps. Each step shifts the value right by one bit and, if the bit shifted out was 1, XORs in the mask 16'h0409 (bits 10, 3 and 0 set). The result is 16 bits.
- R3: When neither `vld` nor `clr` is high at an edge, `crc` keeps its value.
- R4: When `clr` is high at an edge, `crc` becomes 0 and `err` becomes 0 after that edge, whatever `vld`, `cmp` and `din` are.
- R5: When `cmp` is high, `clr` is low and `din` differs from the current `crc` at an edge, `err` is 1 after that edge. It stays 1 until a clear.
- R6: When `cmp` is high and `din` equals the current `crc` (the value before any update in the same cycle), `err` is not set.
- R7: Absorbing a word equal to the current `crc` leaves `crc` equal to 0. The comparison and the absorption may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Start of a new packet: zero the value and the error flag |
| vld | input | 1 | Absorb `din` this cycle |
| din | input | 16 | Data or check word |
| cmp | input | 1 | Compare `din` with the current value |
| crc | output | 16 | Running check value |
| err | output | 1 | Sticky mismatch flag |

## Verification
A wrong feedback tap or a missing reduction step shows up in `crc` on the edge that absorbs the first word. The value is then wrong from that word onward for the rest of the packet, so a long chain of words checked every cycle exposes it at once. A flag that fails to hold, or a compare that samples the updated value instead of the old one, shows up in `err` one cycle after the compare strobe. The zero residue after the check word is absorbed gives an end-to-end check of the whole receive sequence.

// File: rtl/crc16_word.sv
module crc16_word #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h0409
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         vld,
  input  logic [W-1:0] din,
  input  logic         cmp,
  output logic [W-1:0] crc,
  output logic         err
);

  function automatic logic [W-1:0] absorb(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] x;
    x = c ^ d;
    for (int i = 0; i < W; i++)
      x = (x >> 1) ^ (x[0] ? POLY : '0);
    return x;
  endfunction

  logic [W-1:0] nxt;
  logic         miss;

  assign nxt  = absorb(crc, din);
  assign miss = cmp && (din != crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
      err <= 1'b0;
    end else if (clr) begin
      crc <= '0;
      err <= 1'b0;
    end else begin
      if (vld)  crc <= nxt;
      if (miss) err <= 1'b1;
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !vld) |=> $stable(crc));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0 && !err));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);

  // R6
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(cmp) && $past(din) != $past(crc)));

  // R7
  residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr && din == crc) |=> crc == '0);

endmodule

// File: tb/sim_crc16_word.sv
module sim_crc16_word;
  logic clk = 0, rst_n = 0, clr = 0, vld = 0, cmp = 0;
  logic [15:0] din = '0;
  logic [15:0] crc;
  logic err;
  int checks = 0, errors = 0;
  logic [15:0] model;

  always #5 clk = ~clk;

  crc16_word u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld), .din(din),
                 .cmp(cmp), .crc(crc), .err(err));

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [31:0] v;
    logic lsb;
    v = {16'h0, c ^ d};
    repeat (16) begin
      lsb = v[0];
      v = v >> 1;
      if (lsb) v = v ^ 32'h0000_0409;
    end
    return v[15:0];
  endfunction

  task automatic chk16(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: crc actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic chk1(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: err actual %b expected %b", r, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic c, input logic v, input logic p, input logic [15:0] d);
    clr = c; vld = v; cmp = p; din = d;
    step();
    clr = 0; vld = 0; cmp = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    #2;
    chk16("R1", crc, 16'h0000);
    chk1("R1", err, 1'b0);
    #20 rst_n = 1;
    step();
    chk16("R1", crc, 16'h0000);
    chk1("R1", err, 1'b0);

    for (int i = 0; i < 16; i++) begin
      drive(1, 0, 0, '0);
      drive(0, 1, 0, 16'h1 << i);
      chk16("R2 one-hot", crc, ref_crc(16'h0, 16'h1 << i));
    end

    drive(1, 0, 0, '0);
    model = '0;
    d = 16'hACE1;
    for (int n = 0; n < 20000; n++) begin
      d = d ^ (d << 7);
      d = d ^ (d >> 9);
      d = d ^ (d << 8);
      drive(0, 1, 0, d);
      model = ref_crc(model, d);
      chk16("R2 chain", crc, model);
    end

    for (int n = 0; n < 3; n++) begin
      drive(0, 0, 0, 16'hFFFF);
      chk16("R3", crc, model);
    end

    drive(0, 0, 1, model);
    chk1("R6", err, 1'b0);
    drive(0, 0, 1, model ^ 16'h0100);
    chk1("R5", err, 1'b1);
    drive(0, 0, 0, '0);
    chk1("R5 sticky", err, 1'b1);
    drive(0, 0, 1, model);
    chk1("R5 sticky", err, 1'b1);

    drive(1, 1, 1, 16'h1234);
    chk16("R4", crc, 16'h0000);
    chk1("R4", err, 1'b0);

    model = '0;
    for (int n = 0; n < 8; n++) begin
      drive(0, 1, 0, 16'h1111 * n[15:0] + 16'h00F0);
      model = ref_crc(model, 16'h1111 * n[15:0] + 16'h00F0);
    end
    chk16("R2", crc, model);
    drive(0, 1, 1, model);
    chk16("R7", crc, 16'h0000);
    chk1("R6", err, 1'b0);

    finish_run();
  end
endmodule